// File: doc/BRIEF.md
# Virtual Address Privilege and Segment Classifier

This block sits in front of the translation lookaside buffer of a 64-bit processor's memory management unit. Each cycle it takes the privilege fields of the status register, a virtual address and a write flag. It works out the effective privilege level and whether that level uses 64-bit addressing. It then places the address in exactly one of three classes:

- **Direct:** the address maps without translation, and the block supplies the physical address.
- **Translate:** the address must be looked up in the TLB.
- **Error:** the address cannot be reached from the current level, and the block supplies the exception cause code for a load or a store.

All results are registered, so they appear one clock after the inputs are sampled. The TLB, the cache attributes and any segments that only supervisor mode can reach are handled elsewhere.

Top module: `vaddr_region_decoder`

## Requirements
- R1: The privilege level is kernel whenever `exl_i` or `erl_i` is set. Otherwise `ksu_i` selects it: 00 gives kernel, 01 gives supervisor, and 10 or 11 give user. `mode_o` encodes kernel as 00, supervisor as 01 and user as 10.
- R2: `wide_o` equals `kx_i` in kernel level, `sx_i` in supervisor level and `ux_i` in user level.
- R3: At any privilege level, when address bits 63:62 are 2'b10 the access is direct and `paddr_o` equals address bits 43:0.
- R4: Any other address at or below 0x7FFFFFFF goes to the TLB at every privilege level.
- R5: An address whose bits 63:32 are all zero and whose bit 31 is set is sign-extended to 64 bits before it is classified further. No other address is extended.
- R6: At kernel level, an extended address from 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF inclusive is direct, with `paddr_o` equal to the address ANDed with 0x1FFFFFFF. Every other kernel address not covered by R3 or R4 goes to the TLB.
- R7: At supervisor or user level, an address not covered by R3 or R4 raises `addr_err_o`.
- R8: When `addr_err_o` is set, `cause_o` is 5 for a write (`wr_i`=1) and 4 for a read. At all other times `cause_o` is 0.
- R9: `paddr_o` is 0 whenever `direct_o` is clear.
- R10: Outside reset, exactly one of `direct_o`, `use_tlb_o` and `addr_err_o` is set.
- R11: Outputs show the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ksu_i | input | 2 | Privilege level field |
| exl_i | input | 1 | Exception level bit |
| erl_i | input | 1 | Error level bit |
| ux_i | input | 1 | 64-bit addressing enable, user |
| sx_i | input | 1 | 64-bit addressing enable, supervisor |
| kx_i | input | 1 | 64-bit addressing enable, kernel |
| vaddr_i | input | 64 | Virtual address |
| wr_i | input | 1 | Access is a store |
| mode_o | output | 2 | Resolved privilege level |
| wide_o | output | 1 | 64-bit addressing in force |
| direct_o | output | 1 | Address maps without translation |
| paddr_o | output | 44 | Physical address for a direct access |
| use_tlb_o | output | 1 | Address needs TLB translation |
| addr_err_o | output | 1 | Address error |
| cause_o | output | 5 | Exception cause code |

## Verification
Each segment is exercised from each privilege level. The same address is applied from kernel, supervisor and user, which separates the mode check from the range check. Addresses at the exact edges of the regions are applied to catch off-by-one errors in the comparisons: 0x7FFFFFFF, 0x80000000, 0xFFFFFFFFBFFFFFFF and 0xFFFFFFFFC0000000. Addresses with the upper half zero are paired with ones that have a single upper bit set, which shows whether sign extension is applied only where it should be. A sweep over every combination of the status fields checks the level resolution and the selection of the 64-bit addressing bit.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  typedef enum logic [1:0] {
    PRIV_KERN = 2'b00,
    PRIV_SUP  = 2'b01,
    PRIV_USER = 2'b10
  } priv_e;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 5'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 5'd5;

  typedef struct packed {
    logic direct;
    logic use_tlb;
    logic addr_err;
  } seg_class_t;
endpackage

// File: rtl/vseg_priv.sv
module vseg_priv
  import vseg_pkg::*;
(
  input  logic [1:0] ksu,
  input  logic       exl,
  input  logic       erl,
  input  logic       ux,
  input  logic       sx,
  input  logic       kx,
  output priv_e      mode,
  output logic       wide
);
  always_comb begin
    if (exl || erl) begin
      mode = PRIV_KERN;
    end else begin
      unique case (ksu)
        2'b00:   mode = PRIV_KERN;
        2'b01:   mode = PRIV_SUP;
        default: mode = PRIV_USER;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      PRIV_KERN: wide = kx;
      PRIV_SUP:  wide = sx;
      default:   wide = ux;
    endcase
  end
endmodule

// File: rtl/vseg_decode.sv
module vseg_decode
  import vseg_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 44,
  parameter int DIRECT_W = 29,
  parameter bit PASS_EN  = 1'b1
) (
  input  logic [VA_W-1:0]    va,
  input  logic               wr,
  input  logic               kern,
  output seg_class_t         cls,
  output logic [PA_W-1:0]    paddr,
  output logic [CAUSE_W-1:0] cause
);
  localparam int HALF = VA_W / 2;

  logic            phys_hit;
  logic            low_hit;
  logic            need_ext;
  logic [VA_W-1:0] ext_va;
  logic            kwin_hit;

  generate
    if (PASS_EN) begin : g_pass
      assign phys_hit = (va[VA_W-1 -: 2] == 2'b10);
    end else begin : g_nopass
      assign phys_hit = 1'b0;
    end
  endgenerate

  assign low_hit  = (va[VA_W-1:HALF-1] == '0);
  assign need_ext = (va[VA_W-1:HALF] == '0) && va[HALF-1];
  assign ext_va   = need_ext ? {{HALF{1'b1}}, va[HALF-1:0]} : va;
  assign kwin_hit = (&ext_va[VA_W-1:HALF-1]) && !ext_va[HALF-2];

  always_comb begin
    cls   = '0;
    paddr = '0;
    cause = CAUSE_NONE;
    if (phys_hit) begin
      cls.direct = 1'b1;
      paddr      = va[PA_W-1:0];
    end else if (low_hit) begin
      cls.use_tlb = 1'b1;
    end else if (kern) begin
      if (kwin_hit) begin
        cls.direct = 1'b1;
        paddr      = PA_W'(ext_va[DIRECT_W-1:0]);
      end else begin
        cls.use_tlb = 1'b1;
      end
    end else begin
      cls.addr_err = 1'b1;
      cause        = wr ? CAUSE_STORE : CAUSE_LOAD;
    end
  end
endmodule

// File: rtl/vaddr_region_decoder.sv
module vaddr_region_decoder
  import vseg_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 44,
  parameter int DIRECT_W = 29,
  parameter bit PASS_EN  = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          ksu_i,
  input  logic                exl_i,
  input  logic                erl_i,
  input  logic                ux_i,
  input  logic                sx_i,
  input  logic                kx_i,
  input  logic [VA_W-1:0]     vaddr_i,
  input  logic                wr_i,
  output logic [1:0]          mode_o,
  output logic                wide_o,
  output logic                direct_o,
  output logic [PA_W-1:0]     paddr_o,
  output logic                use_tlb_o,
  output logic                addr_err_o,
  output logic [CAUSE_W-1:0]  cause_o
);
  priv_e              mode_c;
  logic               wide_c;
  seg_class_t         cls_c;
  logic [PA_W-1:0]    paddr_c;
  logic [CAUSE_W-1:0] cause_c;

  vseg_priv u_priv (
    .ksu  (ksu_i),
    .exl  (exl_i),
    .erl  (erl_i),
    .ux   (ux_i),
    .sx   (sx_i),
    .kx   (kx_i),
    .mode (mode_c),
    .wide (wide_c)
  );

  vseg_decode #(
    .VA_W     (VA_W),
    .PA_W     (PA_W),
    .DIRECT_W (DIRECT_W),
    .PASS_EN  (PASS_EN)
  ) u_dec (
    .va    (vaddr_i),
    .wr    (wr_i),
    .kern  (mode_c == PRIV_KERN),
    .cls   (cls_c),
    .paddr (paddr_c),
    .cause (cause_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o     <= '0;
      wide_o     <= 1'b0;
      direct_o   <= 1'b0;
      paddr_o    <= '0;
      use_tlb_o  <= 1'b0;
      addr_err_o <= 1'b0;
      cause_o    <= '0;
    end else begin
      mode_o     <= mode_c;
      wide_o     <= wide_c;
      direct_o   <= cls_c.direct;
      paddr_o    <= paddr_c;
      use_tlb_o  <= cls_c.use_tlb;
      addr_err_o <= cls_c.addr_err;
      cause_o    <= cause_c;
    end
  end
endmodule

// File: rtl/vseg_checker.sv
module vseg_checker #(
  parameter int VA_W = 64,
  parameter int PA_W = 44
) (
  input logic            clk,
  input logic            rst,
  input logic            exl_i,
  input logic            erl_i,
  input logic [VA_W-1:0] vaddr_i,
  input logic            wr_i,
  input logic [1:0]      mode_o,
  input logic            direct_o,
  input logic [PA_W-1:0] paddr_o,
  input logic            use_tlb_o,
  input logic            addr_err_o,
  input logic [4:0]      cause_o
);
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  p_one_class_r10: assert property (@(posedge clk) disable iff (rst)
    live |-> $onehot({direct_o, use_tlb_o, addr_err_o}));

  p_forced_kernel_r1: assert property (@(posedge clk) disable iff (rst)
    live && $past(exl_i || erl_i) |-> mode_o == 2'b00);

  p_phys_pass_r3: assert property (@(posedge clk) disable iff (rst)
    live && $past(vaddr_i[VA_W-1 -: 2] == 2'b10)
      |-> direct_o && paddr_o == $past(vaddr_i[PA_W-1:0]));

  p_low_tlb_r4: assert property (@(posedge clk) disable iff (rst)
    live && $past(vaddr_i[VA_W-1:31] == '0) |-> use_tlb_o);

  p_err_not_kernel_r7: assert property (@(posedge clk) disable iff (rst)
    live && addr_err_o |-> mode_o != 2'b00);

  p_cause_kind_r8: assert property (@(posedge clk) disable iff (rst)
    live && addr_err_o |-> cause_o == ($past(wr_i) ? 5'd5 : 5'd4));

  p_cause_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !addr_err_o |-> cause_o == 5'd0);

  p_paddr_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !direct_o |-> paddr_o == '0);
endmodule

bind vaddr_region_decoder vseg_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .exl_i      (exl_i),
  .erl_i      (erl_i),
  .vaddr_i    (vaddr_i),
  .wr_i       (wr_i),
  .mode_o     (mode_o),
  .direct_o   (direct_o),
  .paddr_o    (paddr_o),
  .use_tlb_o  (use_tlb_o),
  .addr_err_o (addr_err_o),
  .cause_o    (cause_o)
);

// File: tb/vaddr_region_decoder_test.sv
`timescale 1ns/1ps
module vaddr_region_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ksu = 2'b00;
  logic        exl = 1'b0, erl = 1'b0, ux = 1'b0, sx = 1'b0, kx = 1'b0;
  logic [63:0] va  = 64'd0;
  logic        wr  = 1'b0;
  logic [1:0]  mode_o;
  logic        wide_o, direct_o, use_tlb_o, addr_err_o;
  logic [43:0] paddr_o;
  logic [4:0]  cause_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vaddr_region_decoder uut (
    .clk(clk), .rst(rst), .ksu_i(ksu), .exl_i(exl), .erl_i(erl),
    .ux_i(ux), .sx_i(sx), .kx_i(kx), .vaddr_i(va), .wr_i(wr),
    .mode_o(mode_o), .wide_o(wide_o), .direct_o(direct_o),
    .paddr_o(paddr_o), .use_tlb_o(use_tlb_o), .addr_err_o(addr_err_o),
    .cause_o(cause_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference, written from the requirement text
  task automatic apply(input string tag, input logic [1:0] k, input logic e, input logic r,
                       input logic [2:0] xbits, input logic [63:0] a, input logic w);
    int          m;
    logic        wd, d, t, er;
    logic [63:0] pa, e64;
    int          cz;
    ksu = k; exl = e; erl = r; {ux, sx, kx} = xbits; va = a; wr = w;
    if (e || r)       m = 0;
    else if (k == 0)  m = 0;
    else if (k == 1)  m = 1;
    else              m = 2;
    wd = (m == 0) ? xbits[0] : (m == 1) ? xbits[1] : xbits[2];
    d = 0; t = 0; er = 0; pa = 0; cz = 0;
    if (a[63:62] == 2'b10) begin
      d = 1; pa = a % (64'd1 << 44);
    end else if (a <= 64'h7FFF_FFFF) begin
      t = 1;
    end else begin
      e64 = a;
      if ((a >> 32) == 0) e64 = a | 64'hFFFF_FFFF_0000_0000;
      if (m == 0) begin
        if (e64 >= 64'hFFFF_FFFF_8000_0000 && e64 <= 64'hFFFF_FFFF_BFFF_FFFF) begin
          d = 1; pa = e64 % 64'h2000_0000;
        end else t = 1;
      end else begin
        er = 1; cz = w ? 5 : 4;
      end
    end
    @(negedge clk);
    chk({"R1 mode ", tag}, 64'(mode_o), 64'(m));
    chk({"R2 wide ", tag}, 64'(wide_o), 64'(wd));
    chk({tag, " class"}, 64'({direct_o, use_tlb_o, addr_err_o}), 64'({d, t, er}));
    chk({"R9 paddr ", tag}, 64'(paddr_o), pa);
    chk({"R8 cause ", tag}, 64'(cause_o), 64'(cz));
    chk("R10 one class", 64'($countones({direct_o, use_tlb_o, addr_err_o})), 64'd1);
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " reset outputs"},
        64'({mode_o, wide_o, direct_o, paddr_o, use_tlb_o, addr_err_o, cause_o}), 64'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    ksu = 2'b10; va = 64'h9000_0000_0000_0001; kx = 1'b1; ux = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state("R11");
    rst = 1'b0;
    // R4 low addresses from each level
    apply("R4 user low",     2'b10, 0, 0, 3'b000, 64'h0000_0000_0040_0000, 0);
    apply("R4 kern low",     2'b00, 0, 0, 3'b001, 64'h0000_0000_0000_0000, 1);
    apply("R4 boundary",     2'b01, 0, 0, 3'b010, 64'h0000_0000_7FFF_FFFF, 0);
    // R5 sign extension
    apply("R5 user 80000000",   2'b10, 0, 0, 3'b100, 64'h0000_0000_8000_0000, 0);
    apply("R5 kern A0000010",   2'b00, 0, 0, 3'b000, 64'h0000_0000_A000_0010, 0);
    apply("R5 kern no ext",     2'b00, 0, 0, 3'b000, 64'h0000_0001_8000_0000, 0);
    apply("R5 user no ext",     2'b10, 0, 0, 3'b000, 64'h0000_0001_8000_0000, 1);
    apply("R5 kern C0000000",   2'b00, 0, 0, 3'b000, 64'h0000_0000_C000_0000, 0);
    // R6 kernel window and its edges
    apply("R6 kseg low",     2'b00, 0, 0, 3'b001, 64'hFFFF_FFFF_8000_1234, 0);
    apply("R6 kseg top",     2'b00, 0, 0, 3'b001, 64'hFFFF_FFFF_BFFF_FFFF, 1);
    apply("R6 above window", 2'b00, 0, 0, 3'b001, 64'hFFFF_FFFF_C000_0000, 0);
    apply("R6 below window", 2'b00, 0, 0, 3'b001, 64'hFFFF_FFFF_7FFF_FFFF, 0);
    apply("R6 xkseg",        2'b00, 0, 0, 3'b001, 64'hC000_0000_0000_0100, 1);
    // R7 and R8 errors
    apply("R7 user store",   2'b10, 0, 0, 3'b100, 64'hFFFF_FFFF_8000_0000, 1);
    apply("R7 super load",   2'b01, 0, 0, 3'b010, 64'hFFFF_FFFF_9000_0000, 0);
    apply("R7 ksu11 store",  2'b11, 0, 0, 3'b100, 64'h4000_0000_0000_0000, 1);
    // R3 physical pass from every level
    apply("R3 user pass",    2'b10, 0, 0, 3'b000, 64'h9000_0012_3456_7890, 1);
    apply("R3 super pass",   2'b01, 0, 0, 3'b000, 64'hBFFF_FFFF_FFFF_FFFF, 0);
    apply("R3 kern pass",    2'b00, 0, 0, 3'b000, 64'h8000_0000_0000_0000, 0);
    // R1 EXL/ERL forcing with a kernel-only address
    apply("R1 exl forces",   2'b10, 1, 0, 3'b101, 64'hFFFF_FFFF_A000_0040, 1);
    apply("R1 erl forces",   2'b01, 0, 1, 3'b011, 64'hFFFF_FFFF_8000_0004, 0);
    // R2 sweep of every status combination
    for (int i = 0; i < 128; i++) begin
      apply("R2 sweep", 2'(i), i[2], i[3], 3'(i >> 4), 64'hFFFF_FFFF_8765_4321, i[0]);
    end
    // R11 synchronous reset in the middle of a run
    @(negedge clk);
    va = 64'hFFFF_FFFF_8000_0010; ksu = 2'b00; kx = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("R11 mid-run");
    rst = 1'b0;
    apply("R11 after reset", 2'b00, 0, 0, 3'b001, 64'hFFFF_FFFF_8000_0010, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule